// File: doc/BRIEF.md
# Exception Entry and Banked Stack Selector

This block models the part of a 64-bit processor core that takes exceptions and chooses the stack pointer. It holds four banked stack pointers (one per exception level), a stack-select bit, the current exception level and a four-bit interrupt mask (D, A, I, F). Each of the four exception types has a simple request input: synchronous, IRQ, FIQ and SError. When a request is accepted, the block picks the target level and records the return PC and the status word for that level. It then switches to the stack of that level and drives the handler address on a next-PC output.

Each handler address is the vector base plus an offset. The offset depends on the exception type and on where the exception came from. An exception-return input undoes an entry: it restores the saved level, stack select and masks, and loads the saved PC. Software can set and clear mask bits, change the stack-select bit, and write the stack banks.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the level is 3, the stack-select bit is 1, all four mask bits are 1, all stack banks and saved registers are 0, and pc_load and exc_taken are 0.
- R2: active_sp shows bank 0 at level 0, and also at any level when the stack-select bit is 0. Otherwise it shows the bank of the current level. A sp_wr writes the active bank, and a bank_wr writes the bank named by bank_idx.
- R3: A spsel_wr sets the stack-select bit from the next cycle, but only at levels 1 to 3. At level 0 it is ignored.
- R4: The mask bits are D=bit 3, A=bit 2, I=bit 1 and F=bit 0. mask_clr clears the bits set in mask_imm, and mask_set sets them. If both are given in one cycle, set wins. Mask writes are ignored in a cycle that takes an exception.
- R5: IRQ is blocked by I, FIQ by F and SError by A. A synchronous request is never blocked.
- R6: When several requests are accepted together, the order is synchronous, then SError, then FIQ, then IRQ. exc_kind reports the type taken: 0 sync, 1 IRQ, 2 FIQ, 3 SError.
- R7: An exception taken at level 0 goes to level 1. One taken at levels 1 to 3 stays at that level. On entry the stack-select bit becomes 1 and all mask bits become 1.
- R8: On entry, the target level's saved PC gets cur_pc. Its saved status gets {level[1:0] at bits 6:5, stack select at bit 4, masks at bits 3:0}, all taken from before the entry. saved_pc and saved_status show the registers of the current level.
- R9: The handler address is vbase plus a group offset plus a type offset. The group offset is 0x000 for current level with stack select 0, 0x200 for current level with stack select 1, 0x400 for a lower level in 64-bit mode and 0x600 for a lower level with lower_narrow=1. The type offset is 0x080 times exc_kind.
- R10: eret at levels 1 to 3 restores level, stack select and masks from the current saved status, and loads the current saved PC into next_pc. At level 0 it has no effect. An exception in the same cycle wins over eret.
- R11: pc_load and exc_taken are one-cycle outputs. They are set in the cycle after an accepted entry or return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_sync | input | 1 | Synchronous exception request |
| req_irq | input | 1 | IRQ request |
| req_fiq | input | 1 | FIQ request |
| req_serr | input | 1 | SError request |
| cur_pc | input | XLEN | Return address recorded on entry |
| lower_narrow | input | 1 | The lower level runs in 32-bit mode |
| vbase | input | XLEN | Vector table base |
| eret | input | 1 | Exception return |
| mask_set | input | 1 | Set the mask bits given in mask_imm |
| mask_clr | input | 1 | Clear the mask bits given in mask_imm |
| mask_imm | input | 4 | Mask immediate (D,A,I,F) |
| spsel_wr | input | 1 | Write the stack-select bit |
| spsel_val | input | 1 | New stack-select value |
| sp_wr | input | 1 | Write the active stack bank |
| sp_wdata | input | XLEN | Data for sp_wr |
| bank_wr | input | 1 | Write a named stack bank |
| bank_idx | input | 2 | Bank written by bank_wr |
| bank_wdata | input | XLEN | Data for bank_wr |
| cur_el | output | 2 | Current exception level |
| sp_sel | output | 1 | Stack-select bit |
| daif | output | 4 | Mask bits |
| active_sp | output | XLEN | Stack pointer in use |
| pc_load | output | 1 | next_pc is to be loaded |
| next_pc | output | XLEN | Handler or return address |
| exc_taken | output | 1 | An exception was entered |
| exc_kind | output | 2 | Type of the exception entered |
| saved_pc | output | XLEN | Saved PC of the current level |
| saved_status | output | 7 | Saved status of the current level |

## Verification
Every result comes from a single register stage. A request, eret, mask write or select write that is applied before a rising edge shows up on cur_el, sp_sel, daif, next_pc, exc_kind, saved_pc and saved_status just after that same edge. active_sp is combinational from the state and the banks, so it also changes at that edge. Each task applies its inputs between edges, waits one edge, and samples one time unit later. It then clears the inputs and, where the pulse outputs matter, waits one more edge to see pc_load and exc_taken drop back to zero.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_sync,
  input  logic            req_irq,
  input  logic            req_fiq,
  input  logic            req_serr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            lower_narrow,
  input  logic [XLEN-1:0] vbase,
  input  logic            eret,
  input  logic            mask_set,
  input  logic            mask_clr,
  input  logic [3:0]      mask_imm,
  input  logic            spsel_wr,
  input  logic            spsel_val,
  input  logic            sp_wr,
  input  logic [XLEN-1:0] sp_wdata,
  input  logic            bank_wr,
  input  logic [1:0]      bank_idx,
  input  logic [XLEN-1:0] bank_wdata,
  output logic [1:0]      cur_el,
  output logic            sp_sel,
  output logic [3:0]      daif,
  output logic [XLEN-1:0] active_sp,
  output logic            pc_load,
  output logic [XLEN-1:0] next_pc,
  output logic            exc_taken,
  output logic [1:0]      exc_kind,
  output logic [XLEN-1:0] saved_pc,
  output logic [6:0]      saved_status
);
  localparam int NLVL = 4;
  localparam int STW  = 7;

  logic [1:0]      el_q;
  logic            sel_q;
  logic [3:0]      msk_q;
  logic [XLEN-1:0] sp_q   [NLVL];
  logic [XLEN-1:0] elr_q  [NLVL];
  logic [STW-1:0]  spsr_q [NLVL];

  wire go_sync = req_sync;
  wire go_serr = req_serr & ~msk_q[2];
  wire go_fiq  = req_fiq  & ~msk_q[0];
  wire go_irq  = req_irq  & ~msk_q[1];
  wire enter   = go_sync | go_serr | go_fiq | go_irq;
  wire leave   = eret & ~enter & (el_q != 2'd0);

  logic [1:0] kind, group, tgt, sp_idx;
  always_comb begin
    if (go_sync)      kind = 2'd0;
    else if (go_serr) kind = 2'd3;
    else if (go_fiq)  kind = 2'd2;
    else              kind = 2'd1;
  end

  assign tgt    = (el_q == 2'd0) ? 2'd1 : el_q;
  assign group  = (el_q == 2'd0) ? (lower_narrow ? 2'd3 : 2'd2)
                                 : (sel_q ? 2'd1 : 2'd0);
  assign sp_idx = (el_q == 2'd0 || !sel_q) ? 2'd0 : el_q;

  wire [XLEN-1:0] vec_off  = XLEN'({group, kind, 7'b0});
  wire [3:0]      msk_next = (msk_q & ~(mask_clr ? mask_imm : 4'b0))
                           | (mask_set ? mask_imm : 4'b0);
  wire [STW-1:0]  cur_st   = {el_q, sel_q, msk_q};
  wire [STW-1:0]  ret_st   = spsr_q[el_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_q      <= 2'd3;
      sel_q     <= 1'b1;
      msk_q     <= 4'hF;
      pc_load   <= 1'b0;
      exc_taken <= 1'b0;
      exc_kind  <= 2'd0;
      next_pc   <= '0;
    end else begin
      pc_load   <= enter | leave;
      exc_taken <= enter;
      if (enter) begin
        el_q     <= tgt;
        sel_q    <= 1'b1;
        msk_q    <= 4'hF;
        exc_kind <= kind;
        next_pc  <= vbase + vec_off;
      end else if (leave) begin
        el_q    <= ret_st[6:5];
        sel_q   <= ret_st[4];
        msk_q   <= ret_st[3:0];
        next_pc <= elr_q[el_q];
      end else begin
        msk_q <= msk_next;
        if (spsel_wr && el_q != 2'd0) sel_q <= spsel_val;
      end
    end
  end

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sp_q[i]   <= '0;
        elr_q[i]  <= '0;
        spsr_q[i] <= '0;
      end else begin
        if (bank_wr && bank_idx == 2'(i))   sp_q[i] <= bank_wdata;
        else if (sp_wr && sp_idx == 2'(i))  sp_q[i] <= sp_wdata;
        if (enter && tgt == 2'(i)) begin
          elr_q[i]  <= cur_pc;
          spsr_q[i] <= cur_st;
        end
      end
    end
  end

  assign cur_el       = el_q;
  assign sp_sel       = sel_q;
  assign daif         = msk_q;
  assign active_sp    = sp_q[sp_idx];
  assign saved_pc     = elr_q[el_q];
  assign saved_status = spsr_q[el_q];
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_sync,
  input logic       req_irq,
  input logic       req_fiq,
  input logic       req_serr,
  input logic       eret,
  input logic [6:0] vbase_lo,
  input logic [1:0] cur_el,
  input logic       sp_sel,
  input logic [3:0] daif,
  input logic       pc_load,
  input logic [6:0] next_pc_lo,
  input logic       exc_taken,
  input logic [1:0] exc_kind
);
  wire no_req = !req_sync && !req_irq && !req_fiq && !req_serr;

  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> daif == 4'hF); // R7
  AST_ENTRY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> cur_el != 2'd0 && sp_sel); // R7
  AST_ENTRY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> pc_load); // R11
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> next_pc_lo == $past(vbase_lo)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && daif[1] && !req_sync && !req_fiq && !req_serr) |=> !exc_taken); // R5
  AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_sync |=> exc_taken && exc_kind == 2'd0); // R6
  AST_SYNC_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_kind == 2'd0) |-> $past(req_sync)); // R6
  AST_ERET_EL0: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && cur_el == 2'd0 && no_req) |=> !pc_load && cur_el == 2'd0); // R10
  AST_SEL_EL0: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el == 2'd0 && no_req) |=> $stable(sp_sel)); // R3
endmodule

bind exc_entry_unit exc_entry_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .req_irq(req_irq),
  .req_fiq(req_fiq), .req_serr(req_serr), .eret(eret),
  .vbase_lo(vbase[6:0]), .cur_el(cur_el), .sp_sel(sp_sel), .daif(daif),
  .pc_load(pc_load), .next_pc_lo(next_pc[6:0]), .exc_taken(exc_taken),
  .exc_kind(exc_kind)
);

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;
  localparam int XLEN = 64;
  localparam logic [63:0] VB = 64'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic req_sync = 0, req_irq = 0, req_fiq = 0, req_serr = 0;
  logic [XLEN-1:0] cur_pc = 0, vbase = VB, sp_wdata = 0, bank_wdata = 0;
  logic lower_narrow = 0, eret = 0, mask_set = 0, mask_clr = 0;
  logic [3:0] mask_imm = 0;
  logic spsel_wr = 0, spsel_val = 0, sp_wr = 0, bank_wr = 0;
  logic [1:0] bank_idx = 0;
  logic [1:0] cur_el, exc_kind;
  logic sp_sel, pc_load, exc_taken;
  logic [3:0] daif;
  logic [XLEN-1:0] active_sp, next_pc, saved_pc;
  logic [6:0] saved_status;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_entry_unit #(.XLEN(XLEN)) u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    req_sync = 0; req_irq = 0; req_fiq = 0; req_serr = 0; eret = 0;
    mask_set = 0; mask_clr = 0; spsel_wr = 0; sp_wr = 0; bank_wr = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk); #1; rst_n = 1;
    chk("R1 el", cur_el, 3); chk("R1 sel", sp_sel, 1); chk("R1 daif", daif, 4'hF);
    chk("R1 load", pc_load, 0); chk("R1 taken", exc_taken, 0); chk("R1 sp", active_sp, 0);
  endtask

  task automatic t_banks();
    for (int i = 0; i < 4; i++) begin
      bank_wr = 1; bank_idx = 2'(i); bank_wdata = 64'h1000 + 64'(i) * 64'h1100; tick();
    end
    chk("R2 el3 h bank", active_sp, 64'h4300);
    spsel_wr = 1; spsel_val = 0; tick();
    chk("R3 sel write", sp_sel, 0); chk("R2 el3 t bank", active_sp, 64'h1000);
  endtask

  task automatic t_ret_to_el0();
    eret = 1; tick();
    chk("R10 el", cur_el, 0); chk("R10 sel", sp_sel, 0); chk("R10 daif", daif, 0);
    chk("R10 load", pc_load, 1); chk("R10 pc", next_pc, 0); chk("R2 el0 sp", active_sp, 64'h1000);
    tick(); chk("R11 load drop", pc_load, 0);
  endtask

  task automatic t_el0_ignores();
    spsel_wr = 1; spsel_val = 1; tick();
    chk("R3 el0 sel ignored", sp_sel, 0);
    eret = 1; tick();
    chk("R10 el0 eret load", pc_load, 0); chk("R10 el0 eret el", cur_el, 0);
  endtask

  task automatic t_irq_el0();
    cur_pc = 64'h1234; req_irq = 1; tick();
    chk("R7 el", cur_el, 1); chk("R7 sel", sp_sel, 1); chk("R7 daif", daif, 4'hF);
    chk("R11 taken", exc_taken, 1); chk("R6 kind", exc_kind, 1);
    chk("R9 lower64 irq", next_pc, VB + 64'h480);
    chk("R8 pc", saved_pc, 64'h1234); chk("R8 status", saved_status, 0);
    chk("R2 el1 h bank", active_sp, 64'h2100);
    sp_wr = 1; sp_wdata = 64'h2200; tick();
    chk("R11 taken drop", exc_taken, 0); chk("R2 sp write", active_sp, 64'h2200);
    eret = 1; tick();
    chk("R10 back el0", cur_el, 0); chk("R10 back pc", next_pc, 64'h1234);
  endtask

  task automatic t_narrow();
    lower_narrow = 1; cur_pc = 64'h2000; req_serr = 1; tick();
    lower_narrow = 0;
    chk("R6 serr kind", exc_kind, 3); chk("R9 lower32 serr", next_pc, VB + 64'h780);
    chk("R8 pc2", saved_pc, 64'h2000); chk("R2 el1 sp", active_sp, 64'h2200);
  endtask

  task automatic t_masks();
    req_irq = 1; tick();
    chk("R5 irq masked load", pc_load, 0); chk("R5 irq masked el", cur_el, 1);
    mask_clr = 1; mask_imm = 4'd2; tick(); chk("R4 clr I", daif, 4'hD);
    mask_clr = 1; mask_imm = 4'd1; tick(); chk("R4 clr F", daif, 4'hC);
    cur_pc = 64'h3000; req_fiq = 1; req_irq = 1; tick();
    chk("R6 fiq over irq", exc_kind, 2); chk("R9 cur h fiq", next_pc, VB + 64'h300);
    chk("R8 status h", saved_status, 7'h3C);
    eret = 1; tick();
    chk("R10 daif", daif, 4'hC); chk("R10 pc2", next_pc, 64'h3000); chk("R10 el1", cur_el, 1);
    mask_set = 1; mask_imm = 4'd2; tick(); chk("R4 set I", daif, 4'hE);
    req_irq = 1; tick(); chk("R5 irq remasked", pc_load, 0);
    mask_set = 1; mask_clr = 1; mask_imm = 4'd1; tick(); chk("R4 set wins", daif, 4'hF);
    mask_clr = 1; mask_imm = 4'hF; tick(); chk("R4 clr all", daif, 0);
  endtask

  task automatic t_priority();
    cur_pc = 64'h4000; req_sync = 1; req_serr = 1; req_fiq = 1; req_irq = 1; tick();
    chk("R6 sync first", exc_kind, 0); chk("R9 cur h sync", next_pc, VB + 64'h200);
    eret = 1; tick();
    req_serr = 1; req_fiq = 1; req_irq = 1; tick();
    chk("R6 serr over fiq", exc_kind, 3); chk("R9 cur h serr", next_pc, VB + 64'h380);
    eret = 1; tick(); chk("R10 masks", daif, 0);
  endtask

  task automatic t_sp0_group();
    spsel_wr = 1; spsel_val = 0; tick(); chk("R2 el1 t bank", active_sp, 64'h1000);
    cur_pc = 64'h5000; req_sync = 1; tick();
    chk("R9 cur t sync", next_pc, VB); chk("R7 sel set", sp_sel, 1);
    chk("R8 status t", saved_status, 7'h20); chk("R2 entry bank", active_sp, 64'h2200);
    eret = 1; tick(); chk("R10 sel", sp_sel, 0); chk("R2 ret bank", active_sp, 64'h1000);
  endtask

  task automatic t_collide();
    cur_pc = 64'h6000; eret = 1; req_sync = 1; mask_clr = 1; mask_imm = 4'hF; tick();
    chk("R10 exc over eret", exc_taken, 1); chk("R10 exc pc", next_pc, VB);
    chk("R4 mask ignored", daif, 4'hF); chk("R8 pc3", saved_pc, 64'h6000);
  endtask

  initial begin
    t_reset(); t_banks(); t_ret_to_el0(); t_el0_ignores(); t_irq_el0();
    t_narrow(); t_masks(); t_priority(); t_sp0_group(); t_collide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule